// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit ports, A and B, and moves data in one direction at a time. Each direction has its own storage register, and each register is loaded by its own capture clock. The port that receives data can be driven with the live value on the opposite port or with the stored copy of it. Per-direction select inputs make that choice. An active-low output enable and a direction input decide which port, if either, is driven.

Each bidirectional pin group is modelled as an input vector, an output vector and one output-enable bit. The pad sits outside the block and combines them. Storing does not depend on driving. Both registers keep capturing while both ports are isolated, and either register can load while the opposite port is driven.

A build-time parameter inverts the data path in both directions. The inversion is applied after the storage registers, so the registers always hold the uninverted captured data.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising edge of `clk_ab`, the A-side register loads `a_in`. On a rising edge of `clk_ba`, the B-side register loads `b_in`. Each load counts once that clock domain has left reset.
- R2: While `oe_n` is 0, `dir`=1 asserts `b_oe` and deasserts `a_oe`, so A drives B. While `oe_n` is 0, `dir`=0 asserts `a_oe` and deasserts `b_oe`, so B drives A.
- R3: While `oe_n` is 1, `a_oe` and `b_oe` are both 0, whatever the value of `dir`.
- R4: `a_oe` and `b_oe` are never 1 at the same time.
- R5: With `sel_ab`=0, `b_out` follows the live `a_in` combinationally. With `sel_ab`=1, `b_out` shows the A-side register.
- R6: With `sel_ba`=0, `a_out` follows the live `b_in` combinationally. With `sel_ba`=1, `a_out` shows the B-side register.
- R7: While `oe_n` is 1, both registers still capture on their clocks. The captured values appear on the outputs once the outputs are enabled with the stored selection.
- R8: While port B is driven (`dir`=1, `oe_n`=0), both registers can capture in the same interval. The stored values are then readable through both selects.
- R9: With `INVERT`=1, `a_out` and `b_out` are the bitwise complement of the values that R5 and R6 give for `INVERT`=0. Both the live and the stored paths are complemented.
- R10: While `rst_n` is 0, both registers are cleared to zero without waiting for a clock edge. Release of reset takes effect two edges later in each capture clock domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock for the A-side register |
| clk_ba | input | 1 | Capture clock for the B-side register |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1: A drives B, 0: B drives A |
| sel_ab | input | 1 | Source for B outputs: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A outputs: 0 live B, 1 stored B |
| a_in | input | WIDTH | Value seen on port A pins |
| a_out | output | WIDTH | Value to drive onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | WIDTH | Value seen on port B pins |
| b_out | output | WIDTH | Value to drive onto port B |
| b_oe | output | 1 | Drive enable for port B |

## Verification
A wrong value in either storage register has no effect on the ports until the matching select picks stored data. When that select is already 1, the error appears on the opposite port's output in the same interval as the capture edge. The bench therefore reads every capture back through the stored selection, in both orders of enable and capture.

A fault in the enable decode shows at once, as both enables set or as a port driven while isolated. The bench sweeps every `oe_n`/`dir` combination to catch it. A second instance built with inversion checks that both paths are complemented and that the stored data stays true.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef enum logic {
    FLOW_B_TO_A = 1'b0,
    FLOW_A_TO_B = 1'b1
  } flow_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  // shift ones in after release; assertion is immediate
  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

  // R1: every edge out of reset captures the sampled input
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));

endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);

  flow_e flow;

  always_comb begin
    flow = flow_e'(dir);
    a_oe = 1'b0;
    b_oe = 1'b0;
    if (!oe_n) begin
      unique case (flow)
        FLOW_A_TO_B: b_oe = 1'b1;
        FLOW_B_TO_A: a_oe = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);

  logic [WIDTH-1:0] pick;
  src_e             src;

  always_comb begin
    src = src_e'(sel);
    unique case (src)
      SRC_STORED: pick = stored;
      default:    pick = live;
    endcase
  end

  generate
    if (INVERT) begin : g_inv
      assign out = ~pick;
    end else begin : g_true
      assign out = pick;
    end
  endgenerate

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH     = 8,
  parameter bit INVERT    = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? '1 : '0;

  logic             rst_ab_n;
  logic             rst_ba_n;
  logic [WIDTH-1:0] reg_a_q;
  logic [WIDTH-1:0] reg_b_q;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst_ab (
    .clk(clk_ab), .rst_n(rst_n), .rst_sync_n(rst_ab_n)
  );

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst_ba (
    .clk(clk_ba), .rst_n(rst_n), .rst_sync_n(rst_ba_n)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk(clk_ab), .rst_n(rst_ab_n), .d(a_in), .q(reg_a_q)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk(clk_ba), .rst_n(rst_ba_n), .d(b_in), .q(reg_b_q)
  );

  xcvr_out_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_b (
    .sel(sel_ab), .live(a_in), .stored(reg_a_q), .out(b_out)
  );

  xcvr_out_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_a (
    .sel(sel_ba), .live(b_in), .stored(reg_b_q), .out(a_out)
  );

  xcvr_dir_ctrl u_dir (
    .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
  );

  // R4: never both ports driven
  p_one_driver_r4: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    !(a_oe && b_oe));

  // R3: isolation releases both ports
  p_isolate_r3: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    oe_n |-> (!a_oe && !b_oe));

  // R5: stored selection shows the A-side register on B
  p_b_stored_r5: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    sel_ab |-> (b_out == (reg_a_q ^ POL_MASK)));

  // R6: stored selection shows the B-side register on A
  p_a_stored_r6: assert property (@(posedge clk_ba) disable iff (!rst_ba_n)
    sel_ba |-> (a_out == (reg_b_q ^ POL_MASK)));

endmodule

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  typedef struct {
    string        tag;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;
  } exp_t;

  logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b1, sel_ba = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;

  logic [W-1:0] a_out_t, b_out_t, a_out_i, b_out_i;
  logic a_oe_t, b_oe_t, a_oe_i, b_oe_i;

  logic [W-1:0] m_ra = '0, m_rb = '0;
  exp_t sb_q[$];
  event chk_ev;
  int checks = 0;
  int errors = 0;

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_t), .a_oe(a_oe_t),
    .b_in(b_in), .b_out(b_out_t), .b_oe(b_oe_t)
  );

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_i), .a_oe(a_oe_i),
    .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i)
  );

  task automatic cmp_one(input exp_t e, input string which, input logic [W-1:0] mask,
                         input logic [W-1:0] ao, input logic aoe,
                         input logic [W-1:0] bo, input logic boe);
    checks++;
    if (ao !== (e.a_out ^ mask) || aoe !== e.a_oe ||
        bo !== (e.b_out ^ mask) || boe !== e.b_oe) begin
      errors++;
      $display("FAIL %s [%s]: got a_out=%h a_oe=%b b_out=%h b_oe=%b, exp a_out=%h a_oe=%b b_out=%h b_oe=%b",
               e.tag, which, ao, aoe, bo, boe,
               e.a_out ^ mask, e.a_oe, e.b_out ^ mask, e.b_oe);
    end
  endtask

  // monitor: pops expected items and compares both builds (R9 on the inverted one)
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp_one(e, "true", '0, a_out_t, a_oe_t, b_out_t, b_oe_t);
        cmp_one(e, "R9 inverted", '1, a_out_i, a_oe_i, b_out_i, b_oe_i);
      end
    end
  end

  // driver side: expected values from the requirements
  task automatic expect_now(input string tag);
    exp_t e;
    #1;
    e.tag   = tag;
    e.a_oe  = !oe_n && !dir;
    e.b_oe  = !oe_n && dir;
    e.a_out = sel_ba ? m_rb : b_in;
    e.b_out = sel_ab ? m_ra : a_in;
    sb_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic pulse_ab();
    clk_ab = 1'b1;
    m_ra = a_in;
    #(CLK_PERIOD / 2);
    clk_ab = 1'b0;
    #(CLK_PERIOD / 2);
  endtask

  task automatic pulse_ba();
    clk_ba = 1'b1;
    m_rb = b_in;
    #(CLK_PERIOD / 2);
    clk_ba = 1'b0;
    #(CLK_PERIOD / 2);
  endtask

  task automatic release_reset();
    a_in = '0;
    b_in = '0;
    #1;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pulse_ab();
      pulse_ba();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state with stored selection, ports isolated (R3)
    expect_now("R10 R3 reset state");
    #CLK_PERIOD;
    release_reset();
    expect_now("R10 after release");

    // R2 R5: A drives B with live data
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'hA5;
    expect_now("R2 R5 live A to B");
    a_in = 8'h3C;
    expect_now("R5 live follows");
    pulse_ab();
    a_in = 8'h99; sel_ab = 1'b1;
    expect_now("R1 R5 stored A");

    // R2 R6: B drives A
    dir = 1'b0; sel_ba = 1'b0; b_in = 8'h5A;
    expect_now("R2 R6 live B to A");
    pulse_ba();
    b_in = 8'h11; sel_ba = 1'b1;
    expect_now("R1 R6 stored B");

    // R7: capture while isolated
    oe_n = 1'b1; dir = 1'b1;
    a_in = 8'hC3; b_in = 8'h7E;
    expect_now("R3 R4 isolated");
    pulse_ab();
    pulse_ba();
    a_in = 8'h00; b_in = 8'hFF;
    expect_now("R7 isolated captures held");
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    expect_now("R7 stored A after isolation");
    dir = 1'b0; sel_ba = 1'b1;
    expect_now("R7 stored B after isolation");

    // R8: both registers load while B is driven
    dir = 1'b1; sel_ab = 1'b0;
    a_in = 8'hE1; b_in = 8'h1E;
    pulse_ab();
    pulse_ba();
    a_in = 8'h42; b_in = 8'h24;
    sel_ab = 1'b1; sel_ba = 1'b1;
    expect_now("R8 both stored while B driven");

    // R4 R2 R3: sweep of enable and direction
    for (int k = 0; k < 4; k++) begin
      oe_n = k[1]; dir = k[0];
      expect_now("R4 R2 R3 enable sweep");
    end

    // R10: asynchronous clear without a clock edge
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
    rst_n = 1'b0;
    m_ra = '0; m_rb = '0;
    expect_now("R10 async clear");
    release_reset();
    a_in = 8'h81;
    pulse_ab();
    expect_now("R1 R10 capture after release");

    #CLK_PERIOD;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule